// File: doc/BRIEF.md
# Multicycle Instruction Sequencing Controller

This block is the control unit of a narrow multicycle processor datapath whose instruction words are wider than its memory port. It is a Moore state machine. Each instruction starts with a run of fetch beats. Every beat reads one instruction byte from memory into its own slice of the instruction register and advances the program counter. One decode cycle follows, which classifies the opcode. The machine then walks a short, class-specific sequence and returns to the first fetch beat.

All outputs depend on the current state only. The opcode input is consulted in the decode cycle alone, so the datapath may present any value on it at other times. Five instruction classes are supported: byte load, byte store, register-register operation, branch-on-equal and jump. Any other opcode ends the instruction right after decode, with nothing written.

Top module: `mc_seq_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the controller is in fetch beat 0. Its outputs are then the fetch-beat values of R2 with `ir_byte_en_o` = 4'b0001.
- R2: Fetch is four beats in consecutive cycles. Beat k drives `ir_byte_en_o` = 1<<k. Every beat drives `mem_rd_o`=1, `pc_wr_o`=1, `addr_sel_o`=0, `alu_a_sel_o`=0, `alu_b_sel_o`=2'b01, `alu_op_o`=2'b00 and `pc_src_sel_o`=2'b00.
- R3: The cycle after beat 3 is decode. Decode drives `alu_a_sel_o`=0, `alu_b_sel_o`=2'b11 and `alu_op_o`=2'b00, with no strobe or write enable active.
- R4: Opcode 6'h20 (byte load) and opcode 6'h28 (byte store) go from decode to one address cycle. That cycle drives `alu_a_sel_o`=1, `alu_b_sel_o`=2'b10 and `alu_op_o`=2'b00.
- R5: After its address cycle a byte load performs a read cycle (`mem_rd_o`=1, `addr_sel_o`=1). A write-back cycle follows with `reg_wr_o`=1, `reg_dst_sel_o`=0 and `wb_sel_o`=1.
- R6: After its address cycle a byte store performs one write cycle with `mem_wr_o`=1 and `addr_sel_o`=1.
- R7: Opcode 6'h00 (register operation) goes to an execute cycle (`alu_a_sel_o`=1, `alu_b_sel_o`=2'b00, `alu_op_o`=2'b10). A completion cycle follows with `reg_wr_o`=1, `reg_dst_sel_o`=1 and `wb_sel_o`=0.
- R8: Opcode 6'h04 (branch-on-equal) goes to one cycle that drives `alu_a_sel_o`=1, `alu_b_sel_o`=2'b00, `alu_op_o`=2'b01, `pc_wr_cond_o`=1 and `pc_src_sel_o`=2'b01.
- R9: Opcode 6'h02 (jump) goes to one cycle that drives `pc_wr_o`=1 and `pc_src_sel_o`=2'b10.
- R10: The cycle after any final cycle (store write, load write-back, register completion, branch, jump) is fetch beat 0.
- R11: Any other opcode at decode sends the controller straight to fetch beat 0, with no write enable or strobe in between.
- R12: In every state other than decode the opcode input has no effect on the state sequence or on any output. Any output not named for a state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 6 | Opcode field of the instruction register |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| addr_sel_o | output | 1 | Memory address source: 0 program counter, 1 ALU result register |
| ir_byte_en_o | output | 4 | Instruction register byte load enables, one-hot per fetch beat |
| alu_a_sel_o | output | 1 | ALU operand A: 0 program counter, 1 register A |
| alu_b_sel_o | output | 2 | ALU operand B: 00 register B, 01 constant step, 10 immediate, 11 branch offset |
| alu_op_o | output | 2 | ALU operation class: 00 add, 01 subtract, 10 decode funct field |
| pc_wr_o | output | 1 | Unconditional program counter write |
| pc_wr_cond_o | output | 1 | Program counter write qualified by ALU zero |
| pc_src_sel_o | output | 2 | Program counter source: 00 ALU, 01 ALU result register, 10 jump target |
| reg_wr_o | output | 1 | Register file write enable |
| reg_dst_sel_o | output | 1 | Destination register field: 0 rt, 1 rd |
| wb_sel_o | output | 1 | Write-back data: 0 ALU result register, 1 memory data |

## Verification
The opcode input takes a new random value every cycle. The values are drawn from the five legal opcodes and two undefined ones. The reference model takes only the value present at the decode edge, so any leak of the opcode into the fetch, address or completion states appears as a diverging output vector. Back-to-back instructions of every class check the handover from each final cycle to fetch beat 0. Undefined opcodes separate a true skip to fetch from a wrongly entered class sequence. An asynchronous reset pulse in mid-instruction confirms that the controller restarts at beat 0 whatever state it was in.

// File: rtl/mc_seq_pkg.sv
package mc_seq_pkg;

  typedef enum logic [3:0] {
    PH_FETCH,
    PH_DECODE,
    PH_LD_ADDR,
    PH_ST_ADDR,
    PH_LD_RD,
    PH_LD_WB,
    PH_ST_WR,
    PH_EXEC,
    PH_RCOMP,
    PH_BRANCH,
    PH_JUMP
  } phase_e;

  typedef enum logic [2:0] {
    OC_LB,
    OC_SB,
    OC_RTYPE,
    OC_BEQ,
    OC_JUMP,
    OC_NONE
  } opclass_e;

  localparam logic [1:0] ALU_B_REG   = 2'b00;
  localparam logic [1:0] ALU_B_STEP  = 2'b01;
  localparam logic [1:0] ALU_B_IMM   = 2'b10;
  localparam logic [1:0] ALU_B_BOFS  = 2'b11;

  localparam logic [1:0] ALU_OP_ADD   = 2'b00;
  localparam logic [1:0] ALU_OP_SUB   = 2'b01;
  localparam logic [1:0] ALU_OP_FUNCT = 2'b10;

  localparam logic [1:0] PC_SRC_ALU    = 2'b00;
  localparam logic [1:0] PC_SRC_ALUOUT = 2'b01;
  localparam logic [1:0] PC_SRC_JUMP   = 2'b10;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       addr_sel;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic       pc_wr;
    logic       pc_wr_cond;
    logic [1:0] pc_src;
    logic       reg_wr;
    logic       reg_dst;
    logic       wb_sel;
  } ctrl_t;

endpackage

// File: rtl/mc_seq_opclass.sv
module mc_seq_opclass
  import mc_seq_pkg::*;
#(
  parameter int unsigned     OPW      = 6,
  parameter logic [OPW-1:0]  OP_LB    = 6'h20,
  parameter logic [OPW-1:0]  OP_SB    = 6'h28,
  parameter logic [OPW-1:0]  OP_RTYPE = 6'h00,
  parameter logic [OPW-1:0]  OP_BEQ   = 6'h04,
  parameter logic [OPW-1:0]  OP_JUMP  = 6'h02
) (
  input  logic [OPW-1:0] opcode_i,
  output opclass_e       class_o
);

  always_comb begin
    if (opcode_i == OP_LB)         class_o = OC_LB;
    else if (opcode_i == OP_SB)    class_o = OC_SB;
    else if (opcode_i == OP_RTYPE) class_o = OC_RTYPE;
    else if (opcode_i == OP_BEQ)   class_o = OC_BEQ;
    else if (opcode_i == OP_JUMP)  class_o = OC_JUMP;
    else                           class_o = OC_NONE;
  end

endmodule

// File: rtl/mc_seq_fsm.sv
module mc_seq_fsm
  import mc_seq_pkg::*;
#(
  parameter int unsigned FETCH_BEATS = 4,
  localparam int unsigned BW = (FETCH_BEATS > 1) ? $clog2(FETCH_BEATS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  opclass_e      class_i,
  output phase_e        phase_o,
  output logic [BW-1:0] beat_o
);

  localparam logic [BW-1:0] LAST_BEAT = BW'(FETCH_BEATS - 1);

  phase_e        phase_q, phase_d;
  logic [BW-1:0] beat_q, beat_d;

  always_comb begin
    phase_d = PH_FETCH;
    beat_d  = '0;
    unique case (phase_q)
      PH_FETCH: begin
        if (beat_q == LAST_BEAT) begin
          phase_d = PH_DECODE;
        end else begin
          phase_d = PH_FETCH;
          beat_d  = beat_q + BW'(1);
        end
      end
      PH_DECODE: begin
        unique case (class_i)
          OC_LB:    phase_d = PH_LD_ADDR;
          OC_SB:    phase_d = PH_ST_ADDR;
          OC_RTYPE: phase_d = PH_EXEC;
          OC_BEQ:   phase_d = PH_BRANCH;
          OC_JUMP:  phase_d = PH_JUMP;
          default:  phase_d = PH_FETCH;
        endcase
      end
      PH_LD_ADDR: phase_d = PH_LD_RD;
      PH_ST_ADDR: phase_d = PH_ST_WR;
      PH_LD_RD:   phase_d = PH_LD_WB;
      PH_EXEC:    phase_d = PH_RCOMP;
      // final states fall back to the first fetch beat
      default:    phase_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_FETCH;
      beat_q  <= '0;
    end else begin
      phase_q <= phase_d;
      beat_q  <= beat_d;
    end
  end

  assign phase_o = phase_q;
  assign beat_o  = beat_q;

endmodule

// File: rtl/mc_seq_outdec.sv
module mc_seq_outdec
  import mc_seq_pkg::*;
#(
  parameter int unsigned FETCH_BEATS = 4,
  localparam int unsigned BW = (FETCH_BEATS > 1) ? $clog2(FETCH_BEATS) : 1
) (
  input  phase_e                 phase_i,
  input  logic [BW-1:0]          beat_i,
  output ctrl_t                  ctrl_o,
  output logic [FETCH_BEATS-1:0] ir_en_o
);

  for (genvar g = 0; g < FETCH_BEATS; g++) begin : g_ir_en
    assign ir_en_o[g] = (phase_i == PH_FETCH) && (beat_i == BW'(g));
  end

  always_comb begin
    ctrl_o = '0;
    unique case (phase_i)
      PH_FETCH: begin
        ctrl_o.mem_rd    = 1'b1;
        ctrl_o.alu_b_sel = ALU_B_STEP;
        ctrl_o.alu_op    = ALU_OP_ADD;
        ctrl_o.pc_wr     = 1'b1;
        ctrl_o.pc_src    = PC_SRC_ALU;
      end
      PH_DECODE: begin
        // branch target precomputed while operands are read
        ctrl_o.alu_b_sel = ALU_B_BOFS;
        ctrl_o.alu_op    = ALU_OP_ADD;
      end
      PH_LD_ADDR, PH_ST_ADDR: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = ALU_B_IMM;
        ctrl_o.alu_op    = ALU_OP_ADD;
      end
      PH_LD_RD: begin
        ctrl_o.mem_rd   = 1'b1;
        ctrl_o.addr_sel = 1'b1;
      end
      PH_LD_WB: begin
        ctrl_o.reg_wr  = 1'b1;
        ctrl_o.reg_dst = 1'b0;
        ctrl_o.wb_sel  = 1'b1;
      end
      PH_ST_WR: begin
        ctrl_o.mem_wr   = 1'b1;
        ctrl_o.addr_sel = 1'b1;
      end
      PH_EXEC: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = ALU_B_REG;
        ctrl_o.alu_op    = ALU_OP_FUNCT;
      end
      PH_RCOMP: begin
        ctrl_o.reg_wr  = 1'b1;
        ctrl_o.reg_dst = 1'b1;
        ctrl_o.wb_sel  = 1'b0;
      end
      PH_BRANCH: begin
        ctrl_o.alu_a_sel  = 1'b1;
        ctrl_o.alu_b_sel  = ALU_B_REG;
        ctrl_o.alu_op     = ALU_OP_SUB;
        ctrl_o.pc_wr_cond = 1'b1;
        ctrl_o.pc_src     = PC_SRC_ALUOUT;
      end
      PH_JUMP: begin
        ctrl_o.pc_wr  = 1'b1;
        ctrl_o.pc_src = PC_SRC_JUMP;
      end
      default: ctrl_o = '0;
    endcase
  end

endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
  import mc_seq_pkg::*;
#(
  parameter int unsigned    FETCH_BEATS = 4,
  parameter int unsigned    OPW         = 6,
  parameter logic [OPW-1:0] OP_LB       = 6'h20,
  parameter logic [OPW-1:0] OP_SB       = 6'h28,
  parameter logic [OPW-1:0] OP_RTYPE    = 6'h00,
  parameter logic [OPW-1:0] OP_BEQ      = 6'h04,
  parameter logic [OPW-1:0] OP_JUMP     = 6'h02
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [OPW-1:0]         opcode_i,
  output logic                   mem_rd_o,
  output logic                   mem_wr_o,
  output logic                   addr_sel_o,
  output logic [FETCH_BEATS-1:0] ir_byte_en_o,
  output logic                   alu_a_sel_o,
  output logic [1:0]             alu_b_sel_o,
  output logic [1:0]             alu_op_o,
  output logic                   pc_wr_o,
  output logic                   pc_wr_cond_o,
  output logic [1:0]             pc_src_sel_o,
  output logic                   reg_wr_o,
  output logic                   reg_dst_sel_o,
  output logic                   wb_sel_o
);

  localparam int unsigned BW = (FETCH_BEATS > 1) ? $clog2(FETCH_BEATS) : 1;

  opclass_e      op_class;
  phase_e        phase;
  logic [BW-1:0] beat;
  ctrl_t         ctrl;

  mc_seq_opclass #(
    .OPW     (OPW),
    .OP_LB   (OP_LB),
    .OP_SB   (OP_SB),
    .OP_RTYPE(OP_RTYPE),
    .OP_BEQ  (OP_BEQ),
    .OP_JUMP (OP_JUMP)
  ) u_opclass (
    .opcode_i(opcode_i),
    .class_o (op_class)
  );

  mc_seq_fsm #(
    .FETCH_BEATS(FETCH_BEATS)
  ) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .class_i(op_class),
    .phase_o(phase),
    .beat_o (beat)
  );

  mc_seq_outdec #(
    .FETCH_BEATS(FETCH_BEATS)
  ) u_outdec (
    .phase_i(phase),
    .beat_i (beat),
    .ctrl_o (ctrl),
    .ir_en_o(ir_byte_en_o)
  );

  assign mem_rd_o      = ctrl.mem_rd;
  assign mem_wr_o      = ctrl.mem_wr;
  assign addr_sel_o    = ctrl.addr_sel;
  assign alu_a_sel_o   = ctrl.alu_a_sel;
  assign alu_b_sel_o   = ctrl.alu_b_sel;
  assign alu_op_o      = ctrl.alu_op;
  assign pc_wr_o       = ctrl.pc_wr;
  assign pc_wr_cond_o  = ctrl.pc_wr_cond;
  assign pc_src_sel_o  = ctrl.pc_src;
  assign reg_wr_o      = ctrl.reg_wr;
  assign reg_dst_sel_o = ctrl.reg_dst;
  assign wb_sel_o      = ctrl.wb_sel;

endmodule

// File: rtl/mc_seq_ctrl_chk.sv
module mc_seq_ctrl_chk #(
  parameter int unsigned FETCH_BEATS = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   mem_rd_o,
  input logic                   mem_wr_o,
  input logic                   addr_sel_o,
  input logic [FETCH_BEATS-1:0] ir_byte_en_o,
  input logic                   alu_a_sel_o,
  input logic [1:0]             alu_b_sel_o,
  input logic [1:0]             alu_op_o,
  input logic                   pc_wr_o,
  input logic                   pc_wr_cond_o,
  input logic [1:0]             pc_src_sel_o,
  input logic                   reg_wr_o,
  input logic                   reg_dst_sel_o,
  input logic                   wb_sel_o
);

  // R2
  ir_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ir_byte_en_o));

  // R2
  fetch_ctl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ir_byte_en_o) |-> (mem_rd_o && pc_wr_o && !addr_sel_o && !alu_a_sel_o &&
                         alu_b_sel_o == 2'b01 && alu_op_o == 2'b00 &&
                         pc_src_sel_o == 2'b00 && !mem_wr_o && !reg_wr_o));

  // R2
  ir_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ir_byte_en_o[FETCH_BEATS-2:0]) |=> (ir_byte_en_o == ($past(ir_byte_en_o) << 1)));

  // R3
  decode_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_byte_en_o[FETCH_BEATS-1] |=> (ir_byte_en_o == '0 && alu_b_sel_o == 2'b11 &&
                                     !mem_rd_o && !mem_wr_o && !pc_wr_o &&
                                     !pc_wr_cond_o && !reg_wr_o));

  // R5
  load_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && addr_sel_o) |=> (reg_wr_o && wb_sel_o && !reg_dst_sel_o));

  // R6
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  // R8
  branch_ctl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_wr_cond_o |-> (!pc_wr_o && pc_src_sel_o == 2'b01 && alu_op_o == 2'b01));

  // R10
  final_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o || reg_wr_o || pc_wr_cond_o) |=> ir_byte_en_o[0]);

  // R9
  jump_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_wr_o && pc_src_sel_o == 2'b10) |=> ir_byte_en_o[0]);

endmodule

bind mc_seq_ctrl mc_seq_ctrl_chk #(.FETCH_BEATS(FETCH_BEATS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_rd_o     (mem_rd_o),
  .mem_wr_o     (mem_wr_o),
  .addr_sel_o   (addr_sel_o),
  .ir_byte_en_o (ir_byte_en_o),
  .alu_a_sel_o  (alu_a_sel_o),
  .alu_b_sel_o  (alu_b_sel_o),
  .alu_op_o     (alu_op_o),
  .pc_wr_o      (pc_wr_o),
  .pc_wr_cond_o (pc_wr_cond_o),
  .pc_src_sel_o (pc_src_sel_o),
  .reg_wr_o     (reg_wr_o),
  .reg_dst_sel_o(reg_dst_sel_o),
  .wb_sel_o     (wb_sel_o)
);

// File: tb/tb_mc_seq_ctrl.sv
module tb_mc_seq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [5:0] opcode = 6'h00;

  logic       mem_rd, mem_wr, addr_sel, alu_a, pc_wr, pc_wr_cond, reg_wr, reg_dst, wb_sel;
  logic [3:0] ir_en;
  logic [1:0] alu_b, alu_op, pc_src;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  mc_seq_ctrl dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .opcode_i     (opcode),
    .mem_rd_o     (mem_rd),
    .mem_wr_o     (mem_wr),
    .addr_sel_o   (addr_sel),
    .ir_byte_en_o (ir_en),
    .alu_a_sel_o  (alu_a),
    .alu_b_sel_o  (alu_b),
    .alu_op_o     (alu_op),
    .pc_wr_o      (pc_wr),
    .pc_wr_cond_o (pc_wr_cond),
    .pc_src_sel_o (pc_src),
    .reg_wr_o     (reg_wr),
    .reg_dst_sel_o(reg_dst),
    .wb_sel_o     (wb_sel)
  );

  // step codes of the reference model
  localparam int S_DEC = 4, S_ADDR = 5, S_LDRD = 6, S_LDWB = 7, S_STWR = 8,
                 S_EXEC = 9, S_RCOMP = 10, S_BR = 11, S_JMP = 12;

  // {mem_rd, mem_wr, addr_sel, ir[3:0], alu_a, alu_b, alu_op, pc_wr, pc_wr_cond, pc_src, reg_wr, reg_dst, wb}
  function automatic logic [18:0] expect_of(int step);
    logic rd = 0, wr = 0, as = 0, a = 0, pw = 0, pc = 0, rw = 0, rdst = 0, wb = 0;
    logic [3:0] ir = 0;
    logic [1:0] b = 0, op = 0, src = 0;
    if (step < 4) begin
      rd = 1; ir = 4'b0001 << step; b = 2'b01; pw = 1;
    end else begin
      case (step)
        S_DEC:   b = 2'b11;
        S_ADDR:  begin a = 1; b = 2'b10; end
        S_LDRD:  begin rd = 1; as = 1; end
        S_LDWB:  begin rw = 1; wb = 1; end
        S_STWR:  begin wr = 1; as = 1; end
        S_EXEC:  begin a = 1; op = 2'b10; end
        S_RCOMP: begin rw = 1; rdst = 1; end
        S_BR:    begin a = 1; op = 2'b01; pc = 1; src = 2'b01; end
        S_JMP:   begin pw = 1; src = 2'b10; end
        default: ;
      endcase
    end
    return {rd, wr, as, ir, a, b, op, pw, pc, src, rw, rdst, wb};
  endfunction

  int    q[$];
  string tq[$];

  task automatic push_fetch(string first_tag);
    for (int k = 0; k < 4; k++) begin
      q.push_back(k);
      tq.push_back(k == 0 ? first_tag : "R2/R12");
    end
    q.push_back(S_DEC);
    tq.push_back("R3");
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); tq.delete();
      push_fetch("R1");
    end else begin
      int cur;
      cur = q.pop_front();
      void'(tq.pop_front());
      if (cur == S_DEC) begin
        case (opcode)
          6'h20: begin q = {q, S_ADDR, S_LDRD, S_LDWB}; tq = {tq, "R4", "R5", "R5"}; end
          6'h28: begin q = {q, S_ADDR, S_STWR};         tq = {tq, "R4", "R6"};       end
          6'h00: begin q = {q, S_EXEC, S_RCOMP};        tq = {tq, "R7", "R7"};       end
          6'h04: begin q = {q, S_BR};                   tq = {tq, "R8"};             end
          6'h02: begin q = {q, S_JMP};                  tq = {tq, "R9"};             end
          default: push_fetch("R11");
        endcase
      end else if (q.size() == 0) begin
        push_fetch("R10");
      end
    end
  end

  task automatic compare();
    logic [18:0] got, exp;
    got = {mem_rd, mem_wr, addr_sel, ir_en, alu_a, alu_b, alu_op, pc_wr, pc_wr_cond,
           pc_src, reg_wr, reg_dst, wb_sel};
    exp = expect_of(q[0]);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s step %0d: actual %b expected %b", tq[0], q[0], got, exp);
    end
  endtask

  function automatic logic [5:0] pick_opcode();
    case ($urandom_range(0, 6))
      0: return 6'h20;
      1: return 6'h28;
      2: return 6'h00;
      3: return 6'h04;
      4: return 6'h02;
      5: return 6'h3f;
      default: return 6'h23;
    endcase
  endfunction

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      compare();  // R1 during reset
    end
    rst_n = 1'b1;
    // directed classes back to back, then random opcodes every cycle (R12)
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      compare();
      if (cyc == 2001) rst_n = 1'b0;
      if (cyc == 2003) rst_n = 1'b1;
      if (cyc < 60) opcode = (cyc < 12) ? 6'h20 : (cyc < 24) ? 6'h28 : (cyc < 36) ? 6'h00 :
                             (cyc < 48) ? 6'h04 : 6'h02;
      else opcode = pick_opcode();
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule